// File: doc/BRIEF.md
# Multi-Channel DAC Card Update Controller

This block sits between an 8-bit processor bus and a card carrying several 12-bit double-buffered DAC channels. Each channel owns a two-address register pair. A processor write to the even address of a pair loads the channel's upper eight bits. A write to the odd address loads its lower four bits, which travel left-justified in the upper nibble of the byte. The block turns each qualified bus write into that channel's chip select, write strobe and byte-select level. Address bit 0 supplies the byte-select level directly.

A separate transfer-word address gives one data bit to each channel. Writing a byte there pulses the transfer strobe of every channel whose bit is 0 and leaves the others alone. Software can therefore preload new codes into any set of channels and later make all of them take effect together. While the card is deselected, every strobe and the data lines toward the converters rest high.

All outputs are registered. A strobe asserts on the clock after the bus write is first sampled, stays asserted for as long as the write strobe is held, and releases one clock after the write strobe is sampled inactive.

Top module: `mdac_bus_ctrl`

## Requirements
- R1: While `rst` is sampled high, every `dac_cs_n`, `dac_wr_n` and `dac_xfer_n` bit and every `dac_byte_hi` bit is 1 on the next cycle, and `dac_data` is 8'hFF.
- R2: A qualified write is one where `bus_wr_n`=0 and `card_sel_n`=0. A qualified write to the even address of channel k's pair drives `dac_cs_n[k]`=0, `dac_wr_n[k]`=0 and `dac_byte_hi[k]`=1 one cycle later. No other channel's chip select is asserted.
- R3: A qualified write to the odd address (base+1) of channel k drives `dac_byte_hi[k]`=0 together with `dac_cs_n[k]`=0. `dac_byte_hi` stays 1 on every channel that is not being written.
- R4: Each decoded strobe stays asserted for every cycle in which the bus write strobe was sampled low, and returns high one cycle after the write strobe is sampled high.
- R5: A channel base has address bit 1 and bit 0 equal to 0, so only base and base+1 decode. Base+2, base+3 and any address matching neither a pair nor the transfer word assert no chip select and no transfer strobe.
- R6: A qualified write to the transfer-word address drives `dac_xfer_n[i]`=0 for each data bit i that is 0 and keeps it 1 for each bit that is 1. No chip select is asserted during that write.
- R7: Codes loaded into several channels leave their outputs unchanged until a transfer word names them. The channels named in one transfer word all update in the same cycle.
- R8: While `card_sel_n`=1, all strobes stay high and `dac_data` is 8'hFF on the next cycle, even if `bus_wr_n`=0. While the card is selected, `dac_data` repeats `bus_data` one cycle later.
- R9: Writing byte H to the even address and byte L to the odd address of a channel, followed by a transfer, produces the 12-bit code {H, L[7:4]} at that channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Processor address |
| bus_data | input | 8 | Processor write data |
| bus_wr_n | input | 1 | Processor write strobe, active low |
| card_sel_n | input | 1 | Card select, active low |
| dac_data | output | 8 | Data lines to all converters, high when idle |
| dac_cs_n | output | NUM_CH | Per-channel chip select, active low |
| dac_wr_n | output | NUM_CH | Per-channel input-latch write strobe, active low |
| dac_byte_hi | output | NUM_CH | Per-channel byte select: 1 loads the full word, 0 loads only the low nibble |
| dac_xfer_n | output | NUM_CH | Per-channel transfer strobe, active low |

## Verification
The bench builds the block with its defaults: eight channels, an 8-bit address, pairs at 8'h10 + 4·k and the transfer word at 8'h40. With these values, channel 0 and channel 7 are the first and last pairs in the map. The reserved slots base+2 and base+3, the address just past the last pair and the address next to the transfer word all fall between decoded locations. The full eight-bit transfer word maps to all channels, so the bench can test all-ones, sparse and multi-channel transfer patterns. A behavioural model of the converter latches in the bench checks the 12-bit assembly and the simultaneous update of two channels.

// File: rtl/mdac_bus_pkg.sv
package mdac_bus_pkg;

    localparam int NUM_CH_DEF = 8;
    localparam int ADDR_W_DEF = 8;
    localparam int DATA_W     = 8;

    // Strobe bundle toward one converter channel; all fields rest high.
    typedef struct packed {
        logic cs_n;
        logic wr_n;
        logic byte_hi;
        logic xfer_n;
    } ch_strobe_t;

    localparam ch_strobe_t STROBE_REST = '{cs_n: 1'b1, wr_n: 1'b1, byte_hi: 1'b1, xfer_n: 1'b1};

    // Kind of a qualified bus access as seen by one channel.
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_LOAD = 2'd1,
        ACC_XFER = 2'd2
    } acc_kind_e;

    function automatic acc_kind_e classify(input logic wr_act, input logic pair_hit,
                                           input logic xfer_hit, input logic xfer_bit);
        if (wr_act && pair_hit)               return ACC_LOAD;
        if (wr_act && xfer_hit && !xfer_bit)  return ACC_XFER;
        return ACC_NONE;
    endfunction

    function automatic ch_strobe_t build_strobe(input acc_kind_e kind, input logic odd_addr);
        ch_strobe_t s;
        s = STROBE_REST;
        case (kind)
            ACC_LOAD: begin
                s.cs_n    = 1'b0;
                s.wr_n    = 1'b0;
                s.byte_hi = ~odd_addr;
            end
            ACC_XFER: s.xfer_n = 1'b0;
            default:  s = STROBE_REST;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/mdac_pair_decode.sv
module mdac_pair_decode #(
    parameter int              ADDR_W = mdac_bus_pkg::ADDR_W_DEF,
    parameter logic [ADDR_W-1:0] BASE = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic              odd
);
    // Only bit 0 varies inside a pair; bit 1 of the base is 0, so base+1
    // never carries into the compared upper bits.
    localparam logic [ADDR_W-2:0] UPPER = BASE[ADDR_W-1:1];

    always_comb begin
        hit = (addr[ADDR_W-1:1] == UPPER);
        odd = addr[0];
    end
endmodule

// File: rtl/mdac_xfer_decode.sv
module mdac_xfer_decode #(
    parameter int                ADDR_W = mdac_bus_pkg::ADDR_W_DEF,
    parameter logic [ADDR_W-1:0] XADDR  = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    always_comb hit = (addr == XADDR);
endmodule

// File: rtl/mdac_chan_strobe.sv
module mdac_chan_strobe
    import mdac_bus_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_act,
    input  logic       pair_hit,
    input  logic       odd_addr,
    input  logic       xfer_hit,
    input  logic       xfer_bit,
    output ch_strobe_t strobe
);
    acc_kind_e  kind;
    ch_strobe_t nxt;

    always_comb begin
        kind = classify(wr_act, pair_hit, xfer_hit, xfer_bit);
        nxt  = build_strobe(kind, odd_addr);
    end

    always_ff @(posedge clk) begin
        if (rst) strobe <= STROBE_REST;
        else     strobe <= nxt;
    end

    // R2: the write strobe never appears without the chip select
    p_wr_with_cs_r2: assert property (@(posedge clk) disable iff (rst)
        !strobe.wr_n |-> !strobe.cs_n);

    // R3: the low-nibble byte select only accompanies an access to this channel
    p_lsb_needs_cs_r3: assert property (@(posedge clk) disable iff (rst)
        !strobe.byte_hi |-> !strobe.cs_n);

    // R6: a transfer pulse and a data load never coincide
    p_xfer_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !strobe.xfer_n |-> strobe.cs_n);

    // R4: a sampled inactive bus write releases every strobe next cycle
    p_release_r4: assert property (@(posedge clk) disable iff (rst)
        !wr_act |=> (strobe == STROBE_REST));
endmodule

// File: rtl/mdac_bus_ctrl.sv
module mdac_bus_ctrl
    import mdac_bus_pkg::*;
#(
    parameter int                       NUM_CH    = NUM_CH_DEF,
    parameter int                       ADDR_W    = ADDR_W_DEF,
    parameter logic [NUM_CH*ADDR_W-1:0] PAIR_BASE = 64'h2C28_2420_1C18_1410,
    parameter logic [ADDR_W-1:0]        XFER_ADDR = 8'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_wr_n,
    input  logic              card_sel_n,
    output logic [DATA_W-1:0] dac_data,
    output logic [NUM_CH-1:0] dac_cs_n,
    output logic [NUM_CH-1:0] dac_wr_n,
    output logic [NUM_CH-1:0] dac_byte_hi,
    output logic [NUM_CH-1:0] dac_xfer_n
);
    localparam logic [DATA_W-1:0] DATA_REST = {DATA_W{1'b1}};
    localparam int                XBITS     = (NUM_CH < DATA_W) ? NUM_CH : DATA_W;

    logic wr_act;
    logic xfer_hit;

    always_comb wr_act = !bus_wr_n && !card_sel_n;

    mdac_xfer_decode #(.ADDR_W(ADDR_W), .XADDR(XFER_ADDR)) u_xfer_dec (
        .addr (bus_addr),
        .hit  (xfer_hit)
    );

    // Data lines follow the bus while the card is selected, else rest high.
    always_ff @(posedge clk) begin
        if (rst)              dac_data <= DATA_REST;
        else if (!card_sel_n) dac_data <= bus_data;
        else                  dac_data <= DATA_REST;
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic       pair_hit;
        logic       odd;
        logic       xbit;
        ch_strobe_t st;

        mdac_pair_decode #(
            .ADDR_W (ADDR_W),
            .BASE   (PAIR_BASE[ch*ADDR_W +: ADDR_W])
        ) u_pair_dec (
            .addr (bus_addr),
            .hit  (pair_hit),
            .odd  (odd)
        );

        // Channels beyond the transfer word width never see a 0 bit.
        if (ch < XBITS) begin : g_xbit
            always_comb xbit = bus_data[ch];
        end else begin : g_noxbit
            always_comb xbit = 1'b1;
        end

        mdac_chan_strobe u_strobe (
            .clk      (clk),
            .rst      (rst),
            .wr_act   (wr_act),
            .pair_hit (pair_hit),
            .odd_addr (odd),
            .xfer_hit (xfer_hit),
            .xfer_bit (xbit),
            .strobe   (st)
        );

        always_comb begin
            dac_cs_n[ch]    = st.cs_n;
            dac_wr_n[ch]    = st.wr_n;
            dac_byte_hi[ch] = st.byte_hi;
            dac_xfer_n[ch]  = st.xfer_n;
        end
    end

    // R5: at most one channel is selected at any time
    p_cs_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~dac_cs_n));

    // R8: a deselected card leaves every line toward the converters high
    p_idle_high_r8: assert property (@(posedge clk) disable iff (rst)
        card_sel_n |=> (dac_data == DATA_REST) && (&dac_cs_n) && (&dac_xfer_n) && (&dac_wr_n));

    // R1: reset drives all strobes and data to the resting level
    p_reset_rest_r1: assert property (@(posedge clk)
        rst |=> (&dac_cs_n) && (&dac_wr_n) && (&dac_byte_hi) && (&dac_xfer_n) && (dac_data == DATA_REST));

    // R6: transfer pulses never coincide with any chip select
    p_xfer_no_cs_r6: assert property (@(posedge clk) disable iff (rst)
        !(&dac_xfer_n) |-> (&dac_cs_n));
endmodule

// File: tb/mdac_bus_ctrl_tb_top.sv
module mdac_bus_ctrl_tb_top;
    localparam int NCH = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_data = '0;
    logic       bus_wr_n = 1'b1;
    logic       card_sel_n = 1'b1;
    logic [7:0] dac_data;
    logic [NCH-1:0] dac_cs_n, dac_wr_n, dac_byte_hi, dac_xfer_n;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;  // 125 MHz

    mdac_bus_ctrl dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_wr_n(bus_wr_n), .card_sel_n(card_sel_n), .dac_data(dac_data),
        .dac_cs_n(dac_cs_n), .dac_wr_n(dac_wr_n), .dac_byte_hi(dac_byte_hi),
        .dac_xfer_n(dac_xfer_n)
    );

    // Behavioural converter channels: input latches and output registers.
    logic [7:0]  in_hi [NCH];
    logic [3:0]  in_lo [NCH];
    logic [11:0] dreg  [NCH];

    initial begin
        for (int i = 0; i < NCH; i++) begin
            in_hi[i] = '0; in_lo[i] = '0; dreg[i] = '0;
        end
    end

    always @(posedge clk) begin
        for (int i = 0; i < NCH; i++) begin
            if (!dac_cs_n[i] && !dac_wr_n[i]) begin
                if (dac_byte_hi[i]) in_hi[i] <= dac_data;
                in_lo[i] <= dac_data[7:4];
            end
            if (!dac_xfer_n[i]) dreg[i] <= {in_hi[i], in_lo[i]};
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_rest(input string req);
        check(req, {dac_cs_n, dac_wr_n, dac_byte_hi, dac_xfer_n}, 32'hFFFF_FFFF);
        check(req, {24'd0, dac_data}, 32'hFF);
    endtask

    // Qualified write held for len cycles, then released; ends at a negedge.
    task automatic bus_write(input logic [7:0] a, input logic [7:0] d, input int len);
        @(negedge clk);
        bus_addr = a; bus_data = d; bus_wr_n = 1'b0; card_sel_n = 1'b0;
        repeat (len) @(negedge clk);
        bus_wr_n = 1'b1; card_sel_n = 1'b1;
        @(negedge clk);
    endtask

    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] data;
        logic [7:0] cs;
        logic [7:0] bh;
        logic [7:0] xf;
    } vec_t;

    // Pairs at 8'h10 + 4*k; transfer word at 8'h40.
    localparam vec_t VEC [12] = '{
        '{8'h10, 8'hA5, 8'hFE, 8'hFF, 8'hFF},  // R2 ch0 even
        '{8'h11, 8'h30, 8'hFE, 8'hFE, 8'hFF},  // R3 ch0 odd
        '{8'h2C, 8'h5A, 8'h7F, 8'hFF, 8'hFF},  // R2 ch7 even
        '{8'h1D, 8'h90, 8'hF7, 8'hF7, 8'hFF},  // R3 ch3 odd
        '{8'h12, 8'h11, 8'hFF, 8'hFF, 8'hFF},  // R5 reserved base+2
        '{8'h13, 8'h22, 8'hFF, 8'hFF, 8'hFF},  // R5 reserved base+3
        '{8'h40, 8'hF5, 8'hFF, 8'hFF, 8'hF5},  // R6 sparse transfer
        '{8'h41, 8'h00, 8'hFF, 8'hFF, 8'hFF},  // R5 next to transfer word
        '{8'h00, 8'h00, 8'hFF, 8'hFF, 8'hFF},  // R5 below map
        '{8'h30, 8'h00, 8'hFF, 8'hFF, 8'hFF},  // R5 past last pair
        '{8'h40, 8'hFF, 8'hFF, 8'hFF, 8'hFF},  // R6 all ones: nothing
        '{8'h26, 8'h00, 8'hFF, 8'hFF, 8'hFF}   // R5 ch5 base+2
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic [11:0] keep0;
        repeat (3) @(negedge clk);
        check_rest("R1 reset");
        rst = 1'b0;
        @(negedge clk);

        // Table walk
        foreach (VEC[i]) begin
            @(negedge clk);
            bus_addr = VEC[i].addr; bus_data = VEC[i].data;
            bus_wr_n = 1'b0; card_sel_n = 1'b0;
            @(negedge clk);
            check("R2/R5 cs", {24'd0, dac_cs_n}, {24'd0, VEC[i].cs});
            check("R2 wr", {24'd0, dac_wr_n}, {24'd0, VEC[i].cs});
            check("R3 byte", {24'd0, dac_byte_hi}, {24'd0, VEC[i].bh});
            check("R6 xfer", {24'd0, dac_xfer_n}, {24'd0, VEC[i].xf});
            check("R8 data", {24'd0, dac_data}, {24'd0, VEC[i].data});
            bus_wr_n = 1'b1; card_sel_n = 1'b1;
            @(negedge clk);
            check_rest("R4 release");
        end

        // R8: deselected card ignores a write strobe
        @(negedge clk);
        bus_addr = 8'h10; bus_data = 8'h3C; bus_wr_n = 1'b0; card_sel_n = 1'b1;
        @(negedge clk);
        check_rest("R8 deselected");
        // Selected but no write strobe: data follows, no strobes
        card_sel_n = 1'b0; bus_wr_n = 1'b1;
        @(negedge clk);
        check("R8 data follow", {24'd0, dac_data}, 32'h3C);
        check("R8 no strobe", {24'd0, dac_cs_n}, 32'hFF);
        card_sel_n = 1'b1;
        @(negedge clk);

        // R4: long write strobe holds the chip select every cycle
        @(negedge clk);
        bus_addr = 8'h20; bus_data = 8'h77; bus_wr_n = 1'b0; card_sel_n = 1'b0;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            check("R4 held", {24'd0, dac_cs_n}, 32'hEF);
        end
        bus_wr_n = 1'b1;
        @(negedge clk);
        check("R4 end", {24'd0, dac_cs_n}, 32'hFF);
        card_sel_n = 1'b1;
        @(negedge clk);

        // R7/R9: preload ch2 and ch6, outputs hold until transfer
        keep0 = dreg[0];
        bus_write(8'h18, 8'hAB, 1);
        bus_write(8'h19, 8'hC0, 1);
        bus_write(8'h28, 8'h12, 1);
        bus_write(8'h29, 8'h3F, 1);
        check("R7 preload ch2", {20'd0, dreg[2]}, 32'h000);
        check("R7 preload ch6", {20'd0, dreg[6]}, 32'h000);
        @(negedge clk);
        bus_addr = 8'h40; bus_data = 8'hBB; bus_wr_n = 1'b0; card_sel_n = 1'b0;
        @(negedge clk);
        check("R6 pulse ch2+ch6", {24'd0, dac_xfer_n}, 32'hBB);
        check("R7 not yet ch2", {20'd0, dreg[2]}, 32'h000);
        check("R7 not yet ch6", {20'd0, dreg[6]}, 32'h000);
        @(negedge clk);
        check("R9 ch2 code", {20'd0, dreg[2]}, 32'hABC);
        check("R7 ch6 same cycle", {20'd0, dreg[6]}, 32'h123);
        check("R6 ch0 untouched", {20'd0, dreg[0]}, {20'd0, keep0});
        bus_wr_n = 1'b1; card_sel_n = 1'b1;
        @(negedge clk);

        // R1: reset during an active write forces rest
        @(negedge clk);
        bus_addr = 8'h14; bus_data = 8'h55; bus_wr_n = 1'b0; card_sel_n = 1'b0;
        @(negedge clk);
        check("R2 ch1 active", {24'd0, dac_cs_n}, 32'hFD);
        rst = 1'b1;
        @(negedge clk);
        check_rest("R1 reset mid-write");
        rst = 1'b0; bus_wr_n = 1'b1; card_sel_n = 1'b1;
        @(negedge clk);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule